// File: doc/BRIEF.md
# Programmable CCD Readout Timing Sequencer

This block drives the five single-ended timing lines of one CCD pixel readout: CCD reset, integrator reset, the negative integration ramp, the positive integration ramp and the ADC sample-and-convert strobe. It runs from a 50 MHz clock, so every edge it produces falls on a 20 ns grid. The waveform is not fixed in logic. It comes from a small stored program of commands. Each command gives a line pattern and a hold time in clocks, and a full pixel fits in a handful of entries. A typical pixel is reset, integrator reset, ramp down for 25, 50 or 75 clocks, an isolation gap, ramp up for the same length, then a conversion strobe. A pixel of about 91 clocks meets a rate of roughly 550 kpixel/s.

The host fills program memory through a write port while the engine is idle. A start pulse then runs the program from address 0. A loop command repeats a stretch of the program for a whole row, and an end command stops the run. Busy stays high for the whole run. An abort input stops a run at once. A sticky error flag records any write attempted during a run.

The controller has two states. In IDLE the lines are low and busy is low, and start with abort low moves it to RUN. RUN stays put while a command is held or steps to the next command. It goes back to IDLE when an END command's hold completes or when abort is seen.

Top module: `readout_seq`

## Requirements
- R1: After rst_n is released, busy, prog_err and all five timing lines are low.
- R2: In IDLE, start high with abort low makes busy high at the next edge, with the lines showing the pattern of address 0. Start is ignored while busy.
- R3: A program word is {target[26:23], reps[22:15], loop[14], end[13], hold[12:5], pattern[4:0]}. Pattern bit 0 is ccd_rst, bit 1 int_rst, bit 2 ramp_down, bit 3 ramp_up and bit 4 adc_conv. A command drives its pattern for max(hold,1) clocks, and the next command's pattern appears at the following edge with no gap.
- R4: Without a jump, execution moves to the next address, and from the last address (15) it wraps to 0.
- R5: A loop command with reps N jumps to target each time it completes, N times in total, and then falls through. The block from target to the loop command therefore runs N+1 times, and N=0 falls through at once. Loops do not nest.
- R6: When the hold of a command with end set completes, all lines go low and busy goes low at that same edge. End takes priority over loop.
- R7: A write attempted while busy leaves program memory unchanged and sets prog_err at the next edge. prog_err stays high until rst_n.
- R8: abort high while busy makes busy and all lines low at the next edge. The next start runs from address 0 with the loop count re-armed.
- R9: Writes made while idle take effect in the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run from address 0 when idle |
| abort | input | 1 | Stop a run at the next edge |
| wr_en | input | 1 | Program memory write strobe |
| wr_addr | input | 4 | Program memory write address |
| wr_data | input | 27 | Program word, layout in R3 |
| busy | output | 1 | High while a program runs |
| prog_err | output | 1 | Sticky flag for a write attempted during a run |
| ccd_rst | output | 1 | CCD reset gate line |
| int_rst | output | 1 | Integrator reset line |
| ramp_down | output | 1 | Integrate the reset level |
| ramp_up | output | 1 | Integrate the signal level |
| adc_conv | output | 1 | ADC sample/hold and convert strobe |

## Verification
Every result is due exactly one edge after its cause. Start, abort and an ignored write show up in busy, in the lines or in prog_err at the first rising edge after the inputs are sampled. A command of hold H keeps its pattern for H rising edges, and its successor appears on the edge that ends the last hold cycle. The bench model steps once per rising edge on the same sampled inputs. Outputs are compared at every falling edge, half a period after the edge that produced them, so each cycle count is checked exactly. Directed totals of busy, ramp and convert cycles over whole pixel rows back up the per-clock comparison.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int NLINES = 5;
    localparam int HOLD_W = 8;
    localparam int REPS_W = 8;
    localparam int AW     = 4;
    localparam int DEPTH  = 1 << AW;
    localparam int WORD_W = NLINES + HOLD_W + 2 + REPS_W + AW;

    typedef struct packed {
        logic [AW-1:0]     target;
        logic [REPS_W-1:0] reps;
        logic              is_loop;
        logic              is_end;
        logic [HOLD_W-1:0] hold;
        logic [NLINES-1:0] pattern;
    } cmd_t;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;
endpackage

// File: rtl/rs_prog_mem.sv
module rs_prog_mem
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     cur_addr,
    input  logic [AW-1:0]     nxt_addr,
    output logic [AW-1:0]     cur_target,
    output logic [REPS_W-1:0] cur_reps,
    output logic              cur_loop,
    output logic              cur_end,
    output logic [NLINES-1:0] nxt_pattern,
    output logic [HOLD_W-1:0] nxt_hold
);
    cmd_t store [DEPTH];
    cmd_t cur_w, nxt_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (wr_ok) begin
            store[wr_addr] <= cmd_t'(wr_data);
        end
    end

    assign cur_w       = store[cur_addr];
    assign nxt_w       = store[nxt_addr];
    assign cur_target  = cur_w.target;
    assign cur_reps    = cur_w.reps;
    assign cur_loop    = cur_w.is_loop;
    assign cur_end     = cur_w.is_end;
    assign nxt_pattern = nxt_w.pattern;
    assign nxt_hold    = nxt_w.hold;

    logic unused_bits;
    assign unused_bits = ^{cur_w.pattern, cur_w.hold, nxt_w.target, nxt_w.reps,
                           nxt_w.is_loop, nxt_w.is_end};
endmodule

// File: rtl/rs_hold_timer.sv
module rs_hold_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= (len == '0) ? '0 : len - W'(1);
        end else if (remain != '0) begin
            remain <= remain - W'(1);
        end
    end

    assign done = (remain == '0);
endmodule

// File: rtl/rs_loop_unit.sv
module rs_loop_unit #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          eval,
    input  logic [CW-1:0] reps,
    output logic          jump
);
    logic          armed;
    logic [CW-1:0] left;

    assign jump = eval && (armed ? (left != '0) : (reps != '0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            left  <= '0;
        end else if (clear) begin
            armed <= 1'b0;
            left  <= '0;
        end else if (eval) begin
            if (armed) begin
                if (left != '0) left  <= left - CW'(1);
                else            armed <= 1'b0;
            end else if (reps != '0) begin
                armed <= 1'b1;
                left  <= reps - CW'(1);
            end
        end
    end

    // R5
    loop_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !armed && reps != '0 && !clear) |=> armed);
endmodule

// File: rtl/readout_seq.sv
module readout_seq
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              prog_err,
    output logic              ccd_rst,
    output logic              int_rst,
    output logic              ramp_down,
    output logic              ramp_up,
    output logic              adc_conv
);
    seq_state_t        state_q, state_d;
    logic [AW-1:0]     pc_q, nxt_addr;
    logic [NLINES-1:0] lines_q;
    logic              busy_q, err_q;

    logic [AW-1:0]     cur_target;
    logic [REPS_W-1:0] cur_reps;
    logic              cur_loop, cur_end;
    logic [NLINES-1:0] nxt_pattern;
    logic [HOLD_W-1:0] nxt_hold;

    logic tmr_done, go, fin, last, advance, halt, loop_eval, jump, wr_ok;

    assign go        = (state_q == ST_IDLE) && start && !abort;
    assign fin       = (state_q == ST_RUN) && tmr_done && !abort;
    assign last      = fin && cur_end;
    assign advance   = go || (fin && !cur_end);
    assign halt      = ((state_q == ST_RUN) && abort) || last;
    assign loop_eval = fin && !cur_end && cur_loop;
    assign wr_ok     = wr_en && (state_q == ST_IDLE);

    always_comb begin
        if (state_q == ST_IDLE) nxt_addr = '0;
        else if (jump)          nxt_addr = cur_target;
        else                    nxt_addr = pc_q + AW'(1);
    end

    rs_prog_mem u_mem (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_addr(wr_addr),
        .wr_data(wr_data), .cur_addr(pc_q), .nxt_addr(nxt_addr),
        .cur_target(cur_target), .cur_reps(cur_reps), .cur_loop(cur_loop),
        .cur_end(cur_end), .nxt_pattern(nxt_pattern), .nxt_hold(nxt_hold)
    );

    rs_hold_timer #(.W(HOLD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(advance), .len(nxt_hold), .done(tmr_done)
    );

    rs_loop_unit #(.CW(REPS_W)) u_loop (
        .clk(clk), .rst_n(rst_n), .clear(go || abort), .eval(loop_eval),
        .reps(cur_reps), .jump(jump)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go)   state_d = ST_RUN;
            ST_RUN:  if (halt) state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and program counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            lines_q <= '0;
            busy_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (wr_en && state_q == ST_RUN) err_q <= 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        pc_q    <= nxt_addr;
                        lines_q <= nxt_pattern;
                        busy_q  <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (halt) begin
                        lines_q <= '0;
                        busy_q  <= 1'b0;
                    end else if (advance) begin
                        pc_q    <= nxt_addr;
                        lines_q <= nxt_pattern;
                    end
                end
                default: begin
                    lines_q <= '0;
                    busy_q  <= 1'b0;
                end
            endcase
        end
    end

    assign busy      = busy_q;
    assign prog_err  = err_q;
    assign ccd_rst   = lines_q[0];
    assign int_rst   = lines_q[1];
    assign ramp_down = lines_q[2];
    assign ramp_up   = lines_q[3];
    assign adc_conv  = lines_q[4];

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !tmr_done && !abort) |=> $stable(lines_q));
    // R2
    start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && start && !abort) |=> busy_q);
    // R7
    wr_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy_q) |=> err_q);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R8
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && abort) |=> (!busy_q && lines_q == '0));
    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !start) |=> (lines_q == '0 || busy_q));
endmodule

// File: tb/readout_seq_tb.sv
module readout_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, abort = 1'b0, wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [26:0] wr_data = '0;
    logic        busy, prog_err, ccd_rst, int_rst, ramp_down, ramp_up, adc_conv;

    always #4 clk = ~clk;

    readout_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .prog_err(prog_err),
        .ccd_rst(ccd_rst), .int_rst(int_rst), .ramp_down(ramp_down),
        .ramp_up(ramp_up), .adc_conv(adc_conv)
    );

    int    vectors = 0, fails = 0, cycles = 0;
    string tag = "R1";
    int    busy_cnt = 0, adc_cnt = 0, down_cnt = 0;

    // reference model
    logic [26:0] mmem [16];
    bit          m_run = 0, m_busy = 0, m_err = 0, m_armed = 0;
    int          m_pc = 0, m_hold = 0, m_left = 0;
    logic [4:0]  m_lines = '0;

    function automatic logic [26:0] mk(int pat, int hold, bit en, bit lp, int reps, int tgt);
        return {4'(tgt), 8'(reps), lp, en, 8'(hold), 5'(pat)};
    endfunction

    task automatic m_load(int a);
        m_pc    = a;
        m_lines = mmem[a][4:0];
        m_hold  = (mmem[a][12:5] == 0) ? 1 : int'(mmem[a][12:5]);
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mmem[i] = '0;
            m_run = 0; m_busy = 0; m_err = 0; m_armed = 0;
            m_pc = 0; m_hold = 0; m_left = 0; m_lines = '0;
        end else if (m_run) begin
            if (wr_en) m_err = 1;
            if (abort) begin
                m_run = 0; m_busy = 0; m_lines = '0; m_armed = 0;
            end else if (m_hold > 1) begin
                m_hold--;
            end else if (mmem[m_pc][13]) begin
                m_run = 0; m_busy = 0; m_lines = '0;
            end else begin
                int np;
                np = (m_pc + 1) % 16;
                if (mmem[m_pc][14]) begin
                    if (m_armed) begin
                        if (m_left > 0) begin m_left--; np = mmem[m_pc][26:23]; end
                        else m_armed = 0;
                    end else if (mmem[m_pc][22:15] != 0) begin
                        m_armed = 1; m_left = mmem[m_pc][22:15] - 1; np = mmem[m_pc][26:23];
                    end
                end
                m_load(np);
            end
        end else begin
            if (wr_en) mmem[wr_addr] = wr_data;
            if (start && !abort) begin
                m_run = 1; m_busy = 1; m_armed = 0; m_load(0);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if ({adc_conv, ramp_up, ramp_down, int_rst, ccd_rst} !== m_lines ||
                busy !== m_busy || prog_err !== m_err) begin
                fails++;
                $display("FAIL %s: lines=%b busy=%b err=%b expected lines=%b busy=%b err=%b",
                         tag, {adc_conv, ramp_up, ramp_down, int_rst, ccd_rst}, busy, prog_err,
                         m_lines, m_busy, m_err);
            end
            if (busy) busy_cnt++;
            if (adc_conv) adc_cnt++;
            if (ramp_down) down_cnt++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below 50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(string t, int act, int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    task automatic wr(int a, logic [26:0] d);
        @(negedge clk); wr_en = 1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic go_run();
        busy_cnt = 0; adc_cnt = 0; down_cnt = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R1";
        check("R1 busy", busy, 0);
        check("R1 lines", {adc_conv, ramp_up, ramp_down, int_rst, ccd_rst}, 0);
        check("R1 err", prog_err, 0);

        // pixel program: 5+5+25+5+25+26 = 91 clocks, three pixels
        tag = "R9";
        wr(0, mk(5'b00001, 5, 0, 0, 0, 0));
        wr(1, mk(5'b00010, 5, 0, 0, 0, 0));
        wr(2, mk(5'b00100, 25, 0, 0, 0, 0));
        wr(3, mk(5'b00000, 5, 0, 0, 0, 0));
        wr(4, mk(5'b01000, 25, 0, 0, 0, 0));
        wr(5, mk(5'b10000, 26, 0, 1, 2, 0));
        wr(6, mk(5'b00000, 0, 1, 0, 0, 0));
        tag = "R5";
        go_run();
        check("R2 busy after start", busy, 1);
        check("R2 first pattern", ccd_rst, 1);
        wait_idle();
        check("R5 busy cycles", busy_cnt, 274);
        check("R5 convert cycles", adc_cnt, 78);
        check("R3 ramp down cycles", down_cnt, 75);
        check("R6 lines after end", {adc_conv, ramp_up, ramp_down, int_rst, ccd_rst}, 0);

        // write during run is ignored and flagged; start during run ignored
        tag = "R7";
        go_run();
        repeat (10) @(negedge clk);
        wr(2, mk(5'b11111, 25, 1, 0, 0, 0));
        @(negedge clk); start = 1; @(negedge clk); start = 0;
        wait_idle();
        check("R7 err set", prog_err, 1);
        check("R7 program unchanged", busy_cnt, 274);
        check("R7 down unchanged", down_cnt, 75);

        // abort mid-run, then a clean rerun
        tag = "R8";
        go_run();
        repeat (120) @(negedge clk);
        abort = 1; @(negedge clk); abort = 0;
        check("R8 busy after abort", busy, 0);
        check("R8 lines after abort", {adc_conv, ramp_up, ramp_down, int_rst, ccd_rst}, 0);
        go_run();
        wait_idle();
        check("R8 rerun full length", busy_cnt, 274);

        // wrap, loop with count 0, zero hold
        tag = "R4";
        wr(0, mk(5'b00001, 3, 0, 1, 1, 14));
        wr(14, mk(5'b00010, 2, 0, 0, 0, 0));
        wr(15, mk(5'b00100, 2, 0, 0, 0, 0));
        wr(1, mk(5'b01000, 0, 0, 1, 0, 0));
        wr(2, mk(5'b10000, 4, 1, 1, 3, 0));
        go_run();
        wait_idle();
        check("R4 wrap path length", busy_cnt, 15);
        check("R6 end beats loop", adc_cnt, 4);

        // reset clears the sticky flag
        tag = "R1";
        go_run();
        repeat (3) @(negedge clk);
        rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 err after reset", prog_err, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule